// File: doc/BRIEF.md
# Divider Configuration Port for a Frequency Synthesizer

This block stores the three control fields of a clock synthesizer. The first is a 9-bit feedback modulus. The second is a 2-bit output-divide code. The third is a 3-bit test-select code. The block can be written through two paths.

- **Parallel path:** the modulus and divide code come from static input pins, gated by a hold strobe. While the strobe is low, the active values follow the pins. On the strobe's rising edge they are frozen.
- **Serial path:** a three-wire port (serial clock, data and commit strobe) fills a 14-bit shift register. The falling edge of the commit strobe copies the frame into the active fields, but only while the hold strobe is high.

The parallel path always wins. The test-select code can only be set serially. It is held at zero whenever the hold strobe is low. The test-select code drives a multiplexer that puts one of seven probe nodes, or a static low, on a single test output.

All strobes and serial lines are treated as asynchronous. They are brought into the fast system clock through two-flop synchronizers, and their edges are detected in that domain. Each configuration change therefore appears at the outputs a few system clocks after the pin edge.

Top module: `fsyn_cfg`

## Requirements
- R1: While reset is asserted, the modulus output is all ones, the divide-code output is all ones and the test-select output is zero.
- R2: While the hold strobe is low, the modulus and divide-code outputs follow the parallel inputs within four system-clock cycles, and the test-select output is zero.
- R3: After a rising edge of the hold strobe, the parallel values present at that edge are kept, and later changes on the parallel inputs do not affect the outputs.
- R4: Each rising edge of the serial clock shifts the sampled data bit into the 14-bit shift register. Of the 14 bits sent, the first three form the test-select code (first bit is its bit 2). The next two form the divide code, MSB first. The last nine form the modulus, MSB first.
- R5: A falling edge of the commit strobe while the hold strobe is high copies the frame into all three outputs within four system-clock cycles. A rising edge of the commit strobe changes nothing.
- R6: While the hold strobe is high and no commit falling edge occurs, shifting serial data leaves all three outputs unchanged.
- R7: While the hold strobe is low, a commit falling edge is ignored, and the outputs keep following the parallel inputs.
- R8: When the hold strobe goes low, the test-select output returns to zero even if it was set serially before.
- R9: The test output is low when the test-select code is 0. For code k from 1 to 7, the test output equals probe bit k-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_hold | input | 1 | Parallel strobe: low = transparent, rising edge = capture and hold |
| par_mod | input | 9 | Parallel feedback modulus |
| par_div | input | 2 | Parallel output-divide code |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, sampled on the serial clock rising edge |
| ser_commit | input | 1 | Serial commit strobe, acts on its falling edge |
| probe | input | 7 | Internal nodes selectable onto the test output |
| mod_q | output | 9 | Active feedback modulus |
| div_q | output | 2 | Active output-divide code |
| tsel_q | output | 3 | Active test-select code |
| test_out | output | 1 | Selected probe node, or low for code 0 |

## Verification
Parallel values are applied in three patterns, and each pattern tells a different mechanism apart:

- **Alternating bit patterns while transparent:** shows that the latches really follow the pins.
- **Changes after the hold edge:** separates a true capture from continued tracking.
- **Serial frames whose three fields carry distinct random values:** any swap of field order or bit order shows up as a wrong field.

Two further patterns check the gating. A frame is shifted with no commit, and a frame is committed while the hold strobe is low; in both cases the outputs must not move. A serial test-select code is set and then the hold strobe is dropped, to show the forced return to zero. Each committed test-select code is compared against a fixed probe pattern, which catches a mux that is off by one.

// File: rtl/fsyn_cfg.sv
module fsyn_cfg #(
  parameter int MW = 9,
  parameter int NW = 2,
  parameter int TW = 3,
  localparam int FW = TW + NW + MW,
  localparam int PW = (1 << TW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_hold,
  input  logic [MW-1:0] par_mod,
  input  logic [NW-1:0] par_div,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_commit,
  input  logic [PW-1:0] probe,
  output logic [MW-1:0] mod_q,
  output logic [NW-1:0] div_q,
  output logic [TW-1:0] tsel_q,
  output logic          test_out
);

  logic [1:0]    hold_sy;
  logic          hold_d;
  logic [2:0]    sck_sy;
  logic [2:0]    cmt_sy;
  logic [1:0]    dat_sy;
  logic [FW-1:0] shreg;

  wire hold_s = hold_sy[1];
  wire crise  = sck_sy[1] & ~sck_sy[2];
  wire cfall  = cmt_sy[2] & ~cmt_sy[1];
  wire par_ld = ~(hold_s & hold_d);
  wire ser_ld = hold_s & hold_d & cfall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_sy <= '0;
      hold_d  <= 1'b0;
      sck_sy  <= '0;
      cmt_sy  <= '0;
      dat_sy  <= '0;
    end else begin
      hold_sy <= {hold_sy[0], par_hold};
      hold_d  <= hold_s;
      sck_sy  <= {sck_sy[1:0], ser_clk};
      cmt_sy  <= {cmt_sy[1:0], ser_commit};
      dat_sy  <= {dat_sy[0], ser_dat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (crise) shreg <= {shreg[FW-2:0], dat_sy[1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q  <= '1;
      div_q  <= '1;
      tsel_q <= '0;
    end else if (par_ld) begin
      mod_q  <= par_mod;
      div_q  <= par_div;
      tsel_q <= '0;
    end else if (ser_ld) begin
      tsel_q <= shreg[FW-1 -: TW];
      div_q  <= shreg[MW +: NW];
      mod_q  <= shreg[MW-1:0];
    end
  end

  wire [PW:0] nodes = {probe, 1'b0};
  assign test_out = nodes[tsel_q];

  // R2
  tsel_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> tsel_q == '0);

  // R7
  par_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_s && cfall) |=> (mod_q == $past(par_mod) && div_q == $past(par_div)));

  // R6
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_s && hold_d && !cfall) |=> ($stable(mod_q) && $stable(div_q) && $stable(tsel_q)));

  // R5
  commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_s && hold_d && cfall) |=> ({tsel_q, div_q, mod_q} == $past(shreg)));

  // R4
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crise |=> shreg[0] == $past(dat_sy[1]));

  // R9
  test_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tsel_q == '0 |-> !test_out);

endmodule

// File: tb/fsyn_cfg_test.sv
`timescale 1ns/1ps
module fsyn_cfg_test;
  typedef struct {
    logic [14:0] v;
    string       tag;
  } exp_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       par_hold = 0;
  logic [8:0] par_mod = '1;
  logic [1:0] par_div = '1;
  logic       ser_clk = 0, ser_dat = 0, ser_commit = 0;
  logic [6:0] probe = 7'b1010011;
  logic [8:0] mod_q;
  logic [1:0] div_q;
  logic [2:0] tsel_q;
  logic       test_out;

  int checks = 0, errors = 0;
  exp_t exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  fsyn_cfg uut (.clk(clk), .rst_n(rst_n), .par_hold(par_hold), .par_mod(par_mod),
    .par_div(par_div), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_commit(ser_commit),
    .probe(probe), .mod_q(mod_q), .div_q(div_q), .tsel_q(tsel_q), .test_out(test_out));

  function automatic logic tsel_pick(logic [2:0] t);
    return (t == 0) ? 1'b0 : probe[t-1];
  endfunction

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_cfg(logic [2:0] t, logic [1:0] n, logic [8:0] m, string tag);
    exp_t e;
    waitc(6);
    e.v = {tsel_pick(t), t, n, m};
    e.tag = tag;
    exp_q.push_back(e);
    waitc(2);
  endtask

  task automatic shift_frame(logic [13:0] f);
    for (int i = 13; i >= 0; i--) begin
      ser_dat = f[i];
      waitc(4);
      ser_clk = 1;
      waitc(4);
      ser_clk = 0;
    end
  endtask

  task automatic commit();
    ser_commit = 1;
    waitc(5);
    ser_commit = 0;
  endtask

  always begin
    @(negedge clk);
    if (exp_q.size() > 0) begin
      exp_t e = exp_q.pop_front();
      logic [14:0] got = {test_out, tsel_q, div_q, mod_q};
      checks++;
      if (got !== e.v) begin
        errors++;
        $display("FAIL %s: got test=%b t=%0d n=%0d m=%0h, expected test=%b t=%0d n=%0d m=%0h",
          e.tag, got[14], got[13:11], got[10:9], got[8:0],
          e.v[14], e.v[13:11], e.v[10:9], e.v[8:0]);
      end
    end
  end

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [13:0] f;
    waitc(3);
    // R1 reset state
    begin
      exp_t e;
      e.v = {1'b0, 3'd0, 2'b11, 9'h1FF};
      e.tag = "R1 reset";
      exp_q.push_back(e);
      waitc(2);
    end
    rst_n = 1;

    // R2 transparent following
    par_mod = 9'h0C8; par_div = 2'b00;
    expect_cfg(0, 2'b00, 9'h0C8, "R2 follow a");
    par_mod = 9'h155; par_div = 2'b10;
    expect_cfg(0, 2'b10, 9'h155, "R2 follow b");

    // R3 capture on hold rising edge
    par_mod = 9'h106; par_div = 2'b01;
    waitc(2);
    par_hold = 1;
    waitc(6);
    par_mod = 9'h0AA; par_div = 2'b11;
    expect_cfg(0, 2'b01, 9'h106, "R3 held");

    // R4 R5 random serial frames, R9 test mux
    for (int k = 0; k < 6; k++) begin
      f = 14'($urandom);
      f[13:11] = 3'(k + 2);
      shift_frame(f);
      waitc(4);
      commit();
      expect_cfg(f[13:11], f[10:9], f[8:0], "R4/R5/R9 frame");
    end
    // R5 rising edge alone does nothing
    shift_frame(14'h0123);
    ser_commit = 1;
    expect_cfg(f[13:11], f[10:9], f[8:0], "R5 rising edge");
    ser_commit = 0;
    expect_cfg(3'd0, 2'b00, 9'h123, "R5 falling edge");
    shift_frame({3'd1, 2'b10, 9'h1FE});
    commit();
    expect_cfg(3'd1, 2'b10, 9'h1FE, "R9 code one");

    // R6 shifting without commit
    shift_frame({3'd5, 2'b01, 9'h033});
    expect_cfg(3'd1, 2'b10, 9'h1FE, "R6 no commit");

    // R8 hold low forces test select to zero
    par_mod = 9'h190; par_div = 2'b00;
    par_hold = 0;
    expect_cfg(0, 2'b00, 9'h190, "R8 tsel cleared");

    // R7 commit ignored while hold low
    shift_frame({3'd7, 2'b11, 9'h0F0});
    commit();
    expect_cfg(0, 2'b00, 9'h190, "R7 commit ignored");
    par_mod = 9'h0C9;
    expect_cfg(0, 2'b00, 9'h0C9, "R7 still follows");

    waitc(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule